// File: doc/BRIEF.md
# Dual-Clock Audio Sample FIFO with DMA Request Thresholds

This block buffers audio samples between a 32-bit register/DMA port on the system clock and a serial frame engine on an independent bit clock. A transmit queue carries words from the system side to the frame engine. A receive queue carries captured words back to the system side. Both queues are dual-clock FIFOs whose pointers cross between the domains in Gray code. The system side reads fill levels and status from them.

Four programmable levels drive two-level DMA urgency. For each direction there is a normal request and a panic request, and a single DMA enable gates all four. Status flags report empty, full, data-present and needs-service conditions, with a selectable service threshold. Underrun and overrun events in the bit-clock domain raise sticky error bits. Four interrupt pending bits are cleared by writing 1 and can be masked. Flush commands for each direction take effect through the bit-clock domain. A one-bit sync value makes a round trip through the bit-clock domain, so software can confirm that the bit clock is running.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset, tx_empty=1, tx_room=1, rx_has_data=0, rx_full=0, sync_rd=0, irq=0 (with int_en=0), and int_pend[3:1]=0.
- R2: Words pushed with tx_push appear on fe_tx_data in push order. fe_tx_data shows the oldest word, and a fe_tx_pop on bclk advances it. A push while the transmit queue holds DEPTH (64) words is dropped.
- R3: Words pushed with fe_rx_push on bclk appear on rx_rdata in push order, and rx_pop advances them. A push while the receive queue is full is dropped and raises the receive error, int_pend[3].
- R4: dreq_lvl[15:8] is the transmit request level and dreq_lvl[31:24] is the transmit panic level. With dma_en=1, tx_dreq=1 exactly when the transmit fill is at or below the request level, and tx_panic=1 exactly when it is at or below the panic level.
- R5: dreq_lvl[7:0] is the receive request level and dreq_lvl[23:16] is the receive panic level. With dma_en=1, rx_dreq=1 exactly when the receive fill exceeds the request level, and rx_panic=1 exactly when it exceeds the panic level.
- R6: With dma_en=0, tx_dreq, tx_panic, rx_dreq and rx_panic are all 0.
- R7: tx_empty means transmit fill is 0. tx_room means transmit fill is below 64. rx_has_data means receive fill is non-zero. rx_full means receive fill is 64.
- R8: tx_need depends on tx_thr_sel: 0 gives fill==0, 1 gives fill<16, 2 gives fill<48, 3 gives fill<64. rx_need depends on rx_thr_sel: 0 gives fill>=1, 1 gives fill>=16, 2 gives fill>=48, 3 gives fill==64.
- R9: A fe_tx_pop on an empty transmit queue sets int_pend[2]. The error bits int_pend[3:2] stay set until the matching int_clr bit is pulsed.
- R10: int_pend bit 0 follows tx_need and bit 1 follows rx_need. Each pending bit sets while its condition holds and clears on int_clr only when the condition is gone. irq = OR over (int_pend & int_en).
- R11: A tx_clr or rx_clr pulse empties the matching queue after the request has crossed the bit-clock domain, not in the next system cycle. Later pushes then flow normally.
- R12: A value written with sync_we/sync_wdata reaches sync_rd only after passing two flops into the bit-clock domain and two back. The cycle after the write, sync_rd still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (also reset source for the bit-clock domain) |
| tx_push | input | 1 | Write one word into the transmit queue |
| tx_wdata | input | 32 | Transmit word |
| rx_pop | input | 1 | Remove the oldest receive word |
| rx_rdata | output | 32 | Oldest receive word |
| dma_en | input | 1 | Enables the four DMA request outputs |
| dreq_lvl | input | 32 | Packed levels: tx panic, rx panic, tx request, rx request (MSB to LSB) |
| tx_thr_sel | input | 2 | Transmit needs-service threshold select |
| rx_thr_sel | input | 2 | Receive needs-service threshold select |
| tx_clr | input | 1 | Flush the transmit queue |
| rx_clr | input | 1 | Flush the receive queue |
| sync_we | input | 1 | Load the sync bit |
| sync_wdata | input | 1 | New sync bit value |
| sync_rd | output | 1 | Sync bit echoed back through the bit-clock domain |
| int_en | input | 4 | Interrupt mask |
| int_clr | input | 4 | Write-1-to-clear for int_pend |
| int_pend | output | 4 | Pending: 3 rx error, 2 tx error, 1 rx needs reading, 0 tx needs writing |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit urgent DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive urgent DMA request |
| tx_empty | output | 1 | Transmit queue empty |
| tx_room | output | 1 | Transmit queue can accept a word |
| tx_need | output | 1 | Transmit queue needs writing |
| rx_has_data | output | 1 | Receive queue holds data |
| rx_need | output | 1 | Receive queue needs reading |
| rx_full | output | 1 | Receive queue full |
| bclk | input | 1 | Bit clock of the frame engine |
| fe_tx_pop | input | 1 | Frame engine takes a transmit word |
| fe_tx_data | output | 32 | Oldest transmit word |
| fe_rx_push | input | 1 | Frame engine delivers a receive word |
| fe_rx_data | input | 32 | Received word |

## Verification
System-side transmit flags and requests change in the system cycle after the push edge, because the write pointer is local. The bench therefore samples them a few negedges after its last push. Receive flags, error bits and everything the bit-clock side produces arrive only after a two-flop crossing plus the edge detect. The bench waits 20 to 80 system cycles before it samples those. Flush and sync results are checked twice: once in the very next system cycle, where the old value must still show, and once after the round-trip margin, where the new value must show. Bit-clock data is sampled at bclk negedges after a pop edge, and system read data at clk negedges.

// File: rtl/asf_pkg.sv
package asf_pkg;

  localparam int INT_TXW   = 0;
  localparam int INT_RXR   = 1;
  localparam int INT_TXERR = 2;
  localparam int INT_RXERR = 3;

  typedef enum logic [1:0] {
    THR_EDGE    = 2'd0,
    THR_QUARTER = 2'd1,
    THR_THREEQ  = 2'd2,
    THR_LAST    = 2'd3
  } thr_sel_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic at_or_below(input int unsigned fill, input int unsigned lvl);
    return fill <= lvl;
  endfunction

  function automatic logic above(input int unsigned fill, input int unsigned lvl);
    return fill > lvl;
  endfunction

  function automatic logic tx_need_f(input int unsigned fill, input int unsigned depth,
                                     input thr_sel_e sel);
    case (sel)
      THR_EDGE:    return fill == 0;
      THR_QUARTER: return fill < depth / 4;
      THR_THREEQ:  return fill < (3 * depth) / 4;
      default:     return fill < depth;
    endcase
  endfunction

  function automatic logic rx_need_f(input int unsigned fill, input int unsigned depth,
                                     input thr_sel_e sel);
    case (sel)
      THR_EDGE:    return fill >= 1;
      THR_QUARTER: return fill >= depth / 4;
      THR_THREEQ:  return fill >= (3 * depth) / 4;
      default:     return fill == depth;
    endcase
  endfunction

endpackage

// File: rtl/asf_bit_sync.sv
module asf_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/asf_toggle_sync.sv
module asf_toggle_sync (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic       tog;
  logic [2:0] sh;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog <= 1'b0;
    else            tog <= tog ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sh <= '0;
    else            sh <= {sh[1:0], tog};
  end

  assign dst_pulse = sh[2] ^ sh[1];
endmodule

// File: rtl/asf_gray_fifo.sv
module asf_gray_fifo #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [AW:0]   wr_fill,
  output logic          wr_full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic          rd_flush,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   rd_fill,
  output logic          rd_empty
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wbin_nxt;
  logic [AW:0] rbin, rgray, rbin_nxt;
  logic [AW:0] rgray_s1, rgray_s2, wgray_s1, wgray_s2;
  logic [AW:0] rbin_seen, wbin_seen;
  logic        wr_go, rd_go;

  // write domain
  assign rbin_seen = (AW+1)'(asf_pkg::gray_to_bin(32'(rgray_s2)));
  assign wr_fill   = wbin - rbin_seen;
  assign wr_full   = (wr_fill == DEPTH_P);
  assign wr_go     = wr_en & ~wr_full;
  assign wbin_nxt  = wbin + (AW+1)'(wr_go);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_s1 <= '0;
      rgray_s2 <= '0;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= (AW+1)'(asf_pkg::bin_to_gray(32'(wbin_nxt)));
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read domain
  assign wbin_seen = (AW+1)'(asf_pkg::gray_to_bin(32'(wgray_s2)));
  assign rd_fill   = wbin_seen - rbin;
  assign rd_empty  = (rd_fill == '0);
  assign rd_go     = rd_en & ~rd_empty & ~rd_flush;
  assign rbin_nxt  = rd_flush ? wbin_seen : rbin + (AW+1)'(rd_go);
  assign rd_data   = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_s1 <= '0;
      wgray_s2 <= '0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= (AW+1)'(asf_pkg::bin_to_gray(32'(rbin_nxt)));
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
    end
  end
endmodule

// File: rtl/asf_service.sv
module asf_service #(
  parameter int AW    = 6,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW:0]      tx_fill,
  input  logic [AW:0]      rx_fill,
  input  logic             dma_en,
  input  logic [4*LVL_W-1:0] dreq_lvl,
  input  logic [1:0]       tx_thr_sel,
  input  logic [1:0]       rx_thr_sel,
  input  logic             tx_err_evt,
  input  logic             rx_err_evt,
  input  logic [3:0]       int_en,
  input  logic [3:0]       int_clr,
  output logic             tx_dreq,
  output logic             tx_panic,
  output logic             rx_dreq,
  output logic             rx_panic,
  output logic             tx_empty,
  output logic             tx_room,
  output logic             tx_need,
  output logic             rx_has_data,
  output logic             rx_need,
  output logic             rx_full,
  output logic [3:0]       int_pend
);
  localparam int DEPTH = 1 << AW;

  logic [LVL_W-1:0] lvl_rx_req, lvl_tx_req, lvl_rx_pan, lvl_tx_pan;
  logic [3:0]       int_cond;
  int unsigned      txf, rxf;

  assign lvl_rx_req = dreq_lvl[LVL_W-1:0];
  assign lvl_tx_req = dreq_lvl[2*LVL_W-1:LVL_W];
  assign lvl_rx_pan = dreq_lvl[3*LVL_W-1:2*LVL_W];
  assign lvl_tx_pan = dreq_lvl[4*LVL_W-1:3*LVL_W];

  assign txf = 32'(tx_fill);
  assign rxf = 32'(rx_fill);

  assign tx_dreq  = dma_en & asf_pkg::at_or_below(txf, 32'(lvl_tx_req));
  assign tx_panic = dma_en & asf_pkg::at_or_below(txf, 32'(lvl_tx_pan));
  assign rx_dreq  = dma_en & asf_pkg::above(rxf, 32'(lvl_rx_req));
  assign rx_panic = dma_en & asf_pkg::above(rxf, 32'(lvl_rx_pan));

  assign tx_empty    = (txf == 0);
  assign tx_room     = (txf < DEPTH);
  assign rx_has_data = (rxf != 0);
  assign rx_full     = (rxf == DEPTH);
  assign tx_need = asf_pkg::tx_need_f(txf, DEPTH, asf_pkg::thr_sel_e'(tx_thr_sel));
  assign rx_need = asf_pkg::rx_need_f(rxf, DEPTH, asf_pkg::thr_sel_e'(rx_thr_sel));

  assign int_cond[asf_pkg::INT_TXW]   = tx_need;
  assign int_cond[asf_pkg::INT_RXR]   = rx_need;
  assign int_cond[asf_pkg::INT_TXERR] = tx_err_evt;
  assign int_cond[asf_pkg::INT_RXERR] = rx_err_evt;

  for (genvar g = 0; g < 4; g++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_pend[g] <= 1'b0;
      else        int_pend[g] <= (int_pend[g] & ~int_clr[g]) | int_cond[g];
    end
  end

  logic unused_en;
  assign unused_en = ^int_en;
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int LVL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_push,
  input  logic [DW-1:0]        tx_wdata,
  input  logic                 rx_pop,
  output logic [DW-1:0]        rx_rdata,
  input  logic                 dma_en,
  input  logic [4*LVL_W-1:0]   dreq_lvl,
  input  logic [1:0]           tx_thr_sel,
  input  logic [1:0]           rx_thr_sel,
  input  logic                 tx_clr,
  input  logic                 rx_clr,
  input  logic                 sync_we,
  input  logic                 sync_wdata,
  output logic                 sync_rd,
  input  logic [3:0]           int_en,
  input  logic [3:0]           int_clr,
  output logic [3:0]           int_pend,
  output logic                 irq,
  output logic                 tx_dreq,
  output logic                 tx_panic,
  output logic                 rx_dreq,
  output logic                 rx_panic,
  output logic                 tx_empty,
  output logic                 tx_room,
  output logic                 tx_need,
  output logic                 rx_has_data,
  output logic                 rx_need,
  output logic                 rx_full,
  input  logic                 bclk,
  input  logic                 fe_tx_pop,
  output logic [DW-1:0]        fe_tx_data,
  input  logic                 fe_rx_push,
  input  logic [DW-1:0]        fe_rx_data
);
  localparam int DEPTH = 1 << AW;

  // named internal events, visible to the bound checker
  logic          brst_n;
  logic [1:0]    brst_sh;
  logic [AW:0]   tx_fill, rx_fill, tx_fill_b, rx_fill_b;
  logic          tx_rd_empty_b, rx_wr_full_b, tx_full_s, rx_empty_s;
  logic          tx_flush_b, rx_clr_b, rx_flush_s;
  logic          tx_underrun_b, rx_overrun_b, tx_err_evt, rx_err_evt;
  logic          sync_q, sync_b;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) brst_sh <= 2'b00;
    else        brst_sh <= {brst_sh[0], 1'b1};
  end
  assign brst_n = brst_sh[1];

  asf_gray_fifo #(.DW(DW), .AW(AW)) u_txq (
    .wclk(clk), .wrst_n(rst_n), .wr_en(tx_push), .wr_data(tx_wdata),
    .wr_fill(tx_fill), .wr_full(tx_full_s),
    .rclk(bclk), .rrst_n(brst_n), .rd_en(fe_tx_pop), .rd_flush(tx_flush_b),
    .rd_data(fe_tx_data), .rd_fill(tx_fill_b), .rd_empty(tx_rd_empty_b)
  );

  asf_gray_fifo #(.DW(DW), .AW(AW)) u_rxq (
    .wclk(bclk), .wrst_n(brst_n), .wr_en(fe_rx_push), .wr_data(fe_rx_data),
    .wr_fill(rx_fill_b), .wr_full(rx_wr_full_b),
    .rclk(clk), .rrst_n(rst_n), .rd_en(rx_pop), .rd_flush(rx_flush_s),
    .rd_data(rx_rdata), .rd_fill(rx_fill), .rd_empty(rx_empty_s)
  );

  assign tx_underrun_b = fe_tx_pop & tx_rd_empty_b;
  assign rx_overrun_b  = fe_rx_push & rx_wr_full_b;

  asf_toggle_sync u_txclr (
    .src_clk(clk), .src_rst_n(rst_n), .src_pulse(tx_clr),
    .dst_clk(bclk), .dst_rst_n(brst_n), .dst_pulse(tx_flush_b));

  asf_toggle_sync u_rxclr_fwd (
    .src_clk(clk), .src_rst_n(rst_n), .src_pulse(rx_clr),
    .dst_clk(bclk), .dst_rst_n(brst_n), .dst_pulse(rx_clr_b));

  asf_toggle_sync u_rxclr_ack (
    .src_clk(bclk), .src_rst_n(brst_n), .src_pulse(rx_clr_b),
    .dst_clk(clk), .dst_rst_n(rst_n), .dst_pulse(rx_flush_s));

  asf_toggle_sync u_unr (
    .src_clk(bclk), .src_rst_n(brst_n), .src_pulse(tx_underrun_b),
    .dst_clk(clk), .dst_rst_n(rst_n), .dst_pulse(tx_err_evt));

  asf_toggle_sync u_ovr (
    .src_clk(bclk), .src_rst_n(brst_n), .src_pulse(rx_overrun_b),
    .dst_clk(clk), .dst_rst_n(rst_n), .dst_pulse(rx_err_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sync_q <= 1'b0;
    else if (sync_we) sync_q <= sync_wdata;
  end

  asf_bit_sync #(.W(1)) u_sync_fwd (.clk(bclk), .rst_n(brst_n), .d(sync_q), .q(sync_b));
  asf_bit_sync #(.W(1)) u_sync_back (.clk(clk), .rst_n(rst_n), .d(sync_b), .q(sync_rd));

  asf_service #(.AW(AW), .LVL_W(LVL_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .tx_fill(tx_fill), .rx_fill(rx_fill),
    .dma_en(dma_en), .dreq_lvl(dreq_lvl), .tx_thr_sel(tx_thr_sel), .rx_thr_sel(rx_thr_sel),
    .tx_err_evt(tx_err_evt), .rx_err_evt(rx_err_evt), .int_en(int_en), .int_clr(int_clr),
    .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
    .tx_empty(tx_empty), .tx_room(tx_room), .tx_need(tx_need),
    .rx_has_data(rx_has_data), .rx_need(rx_need), .rx_full(rx_full), .int_pend(int_pend)
  );

  assign irq = |(int_pend & int_en);

  logic unused_dbg;
  assign unused_dbg = ^{tx_fill_b, rx_fill_b, tx_full_s, rx_empty_s, DEPTH[0]};
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
  parameter int AW    = 6,
  parameter int LVL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dma_en,
  input logic [4*LVL_W-1:0] dreq_lvl,
  input logic               tx_push,
  input logic               tx_room,
  input logic               tx_empty,
  input logic               tx_dreq,
  input logic               tx_panic,
  input logic               rx_dreq,
  input logic               rx_panic,
  input logic               rx_full,
  input logic               rx_has_data,
  input logic [3:0]         int_pend,
  input logic [3:0]         int_clr,
  input logic [3:0]         int_en,
  input logic               irq,
  input logic               sync_we,
  input logic               sync_q,
  input logic               sync_rd,
  input logic [AW:0]        tx_fill,
  input logic [AW:0]        rx_fill
);
  localparam int DEPTH = 1 << AW;

  assert_tx_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_fill) <= DEPTH);
  assert_rx_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_fill) <= DEPTH);
  assert_full_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_has_data);
  assert_push_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_room) |=> !tx_empty);
  assert_tx_panic_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_panic && dreq_lvl[4*LVL_W-1:3*LVL_W] <= dreq_lvl[2*LVL_W-1:LVL_W]) |-> tx_dreq);
  assert_rx_panic_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_panic && dreq_lvl[3*LVL_W-1:2*LVL_W] >= dreq_lvl[LVL_W-1:0]) |-> rx_dreq);
  assert_dma_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(tx_dreq || tx_panic || rx_dreq || rx_panic));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend[2] && !int_clr[2]) |=> int_pend[2]);
  assert_rxerr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend[3] && !int_clr[3]) |=> int_pend[3]);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 4'b0) |-> !irq);
  assert_sync_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_we && sync_q == sync_rd) |=> $stable(sync_rd));
endmodule

bind audio_sample_fifo asf_checker #(.AW(AW), .LVL_W(LVL_W)) u_asf_checker (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dreq_lvl(dreq_lvl),
  .tx_push(tx_push), .tx_room(tx_room), .tx_empty(tx_empty),
  .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
  .rx_full(rx_full), .rx_has_data(rx_has_data), .int_pend(int_pend),
  .int_clr(int_clr), .int_en(int_en), .irq(irq), .sync_we(sync_we),
  .sync_q(sync_q), .sync_rd(sync_rd), .tx_fill(tx_fill), .rx_fill(rx_fill)
);

// File: tb/audio_sample_fifo_bench.sv
module audio_sample_fifo_bench;
  logic        clk = 0, bclk = 0, rst_n = 0;
  logic        tx_push = 0, rx_pop = 0, dma_en = 0;
  logic [31:0] tx_wdata = 0, dreq_lvl = 0, fe_rx_data = 0;
  logic [31:0] rx_rdata, fe_tx_data;
  logic [1:0]  tx_thr_sel = 0, rx_thr_sel = 0;
  logic        tx_clr = 0, rx_clr = 0, sync_we = 0, sync_wdata = 0, sync_rd;
  logic [3:0]  int_en = 0, int_clr = 0, int_pend;
  logic        irq, tx_dreq, tx_panic, rx_dreq, rx_panic;
  logic        tx_empty, tx_room, tx_need, rx_has_data, rx_need, rx_full;
  logic        fe_tx_pop = 0, fe_rx_push = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always #2 clk = ~clk;
  always #11 bclk = ~bclk;

  audio_sample_fifo u_audio_sample_fifo (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit e_tx_need(int f, logic [1:0] s);
    case (s) 2'd0: return f == 0; 2'd1: return f < 16; 2'd2: return f < 48; default: return f < 64; endcase
  endfunction
  function automatic bit e_rx_need(int f, logic [1:0] s);
    case (s) 2'd0: return f > 0; 2'd1: return f > 15; 2'd2: return f > 47; default: return f == 64; endcase
  endfunction

  task automatic tx_round(int n, logic [31:0] lvl, logic dma, logic [1:0] sel);
    int f;
    @(negedge clk); dreq_lvl = lvl; dma_en = dma; tx_thr_sel = sel;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = $urandom;
      @(negedge clk); tx_push = 1; tx_wdata = d;
      @(negedge clk); tx_push = 0;
      if (txq.size() < 64) txq.push_back(d);
    end
    repeat (3) @(negedge clk);
    f = txq.size();
    check("R7 tx_empty", 32'(tx_empty), 32'(f == 0));
    check("R7 tx_room", 32'(tx_room), 32'(f < 64));
    check("R8 tx_need", 32'(tx_need), 32'(e_tx_need(f, sel)));
    check("R4 R6 tx_dreq", 32'(tx_dreq), 32'(dma && f <= int'(lvl[15:8])));
    check("R4 R6 tx_panic", 32'(tx_panic), 32'(dma && f <= int'(lvl[31:24])));
    repeat (60) @(negedge clk);
    @(negedge bclk);
    while (txq.size() > 0) begin
      check("R2 fe_tx_data order", fe_tx_data, txq.pop_front());
      fe_tx_pop = 1;
      @(negedge bclk);
    end
    fe_tx_pop = 0;
    repeat (20) @(negedge clk);
    check("R7 tx_empty after drain", 32'(tx_empty), 32'd1);
    check("R9 no spurious tx error", 32'(int_pend[2]), 32'd0);
  endtask

  task automatic rx_round(int n, logic [31:0] lvl, logic dma, logic [1:0] sel);
    int f;
    bit ovr;
    ovr = (n > 64);
    @(negedge clk); dreq_lvl = lvl; dma_en = dma; rx_thr_sel = sel;
    @(negedge bclk);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = $urandom;
      fe_rx_push = 1; fe_rx_data = d;
      if (rxq.size() < 64) rxq.push_back(d);
      @(negedge bclk);
    end
    fe_rx_push = 0;
    repeat (20) @(negedge clk);
    f = rxq.size();
    check("R7 rx_has_data", 32'(rx_has_data), 32'(f > 0));
    check("R7 rx_full", 32'(rx_full), 32'(f == 64));
    check("R8 rx_need", 32'(rx_need), 32'(e_rx_need(f, sel)));
    check("R5 R6 rx_dreq", 32'(rx_dreq), 32'(dma && f > int'(lvl[7:0])));
    check("R5 R6 rx_panic", 32'(rx_panic), 32'(dma && f > int'(lvl[23:16])));
    check("R3 rx overrun flag", 32'(int_pend[3]), 32'(ovr));
    if (ovr) begin
      int_clr = 4'b1000; @(negedge clk); int_clr = 0;
      check("R9 rx error cleared", 32'(int_pend[3]), 32'd0);
    end
    while (rxq.size() > 0) begin
      check("R3 rx_rdata order", rx_rdata, rxq.pop_front());
      rx_pop = 1;
      @(negedge clk);
    end
    rx_pop = 0;
    repeat (3) @(negedge clk);
    check("R7 rx empty after drain", 32'(rx_has_data), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (10) @(negedge clk);
    check("R1 reset tx_empty", 32'(tx_empty), 32'd1);
    check("R1 reset tx_room", 32'(tx_room), 32'd1);
    check("R1 reset rx_has_data", 32'(rx_has_data), 32'd0);
    check("R1 reset rx_full", 32'(rx_full), 32'd0);
    check("R1 reset sync_rd", 32'(sync_rd), 32'd0);
    check("R1 reset irq", 32'(irq), 32'd0);
    check("R1 reset int_pend", 32'(int_pend), 32'd0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R1 int_pend[3:1] after reset", 32'(int_pend[3:1]), 32'd0);

    // directed level edges
    tx_round(5, 32'h0600_0500, 1, 2'd0);
    tx_round(6, 32'h0600_0500, 1, 2'd1);
    tx_round(7, 32'h0600_0500, 1, 2'd2);
    tx_round(3, 32'hFFFF_FFFF, 0, 2'd3);
    tx_round(15, 32'h1000_3000, 1, 2'd1);
    tx_round(16, 32'h1000_3000, 1, 2'd1);
    tx_round(48, 32'h1000_3000, 1, 2'd2);
    tx_round(63, 32'h1000_3000, 1, 2'd3);
    tx_round(70, 32'h1000_3000, 1, 2'd3);
    rx_round(0, 32'h0007_0005, 1, 2'd0);
    rx_round(5, 32'h0007_0005, 1, 2'd0);
    rx_round(6, 32'h0007_0005, 1, 2'd1);
    rx_round(8, 32'h0007_0005, 1, 2'd1);
    rx_round(16, 32'h0030_0020, 1, 2'd1);
    rx_round(48, 32'h0030_0020, 0, 2'd2);
    rx_round(70, 32'h0030_0020, 1, 2'd3);
    // constrained random rounds
    for (int r = 0; r < 6; r++) begin
      tx_round(int'($urandom_range(0, 70)), $urandom, 1'($urandom), 2'($urandom));
      rx_round(int'($urandom_range(0, 70)), $urandom, 1'($urandom), 2'($urandom));
    end

    // underrun, sticky error and interrupt mask
    @(negedge bclk); fe_tx_pop = 1; @(negedge bclk); fe_tx_pop = 0;
    repeat (20) @(negedge clk);
    int_en = 4'b0100; @(negedge clk);
    check("R9 tx underrun sets error", 32'(int_pend[2]), 32'd1);
    check("R10 irq from tx error", 32'(irq), 32'd1);
    repeat (5) @(negedge clk);
    check("R9 tx error sticky", 32'(int_pend[2]), 32'd1);
    int_clr = 4'b0100; @(negedge clk); int_clr = 0;
    check("R9 tx error cleared", 32'(int_pend[2]), 32'd0);
    check("R10 irq dropped", 32'(irq), 32'd0);
    tx_thr_sel = 2'd0;
    int_clr = 4'b0001; @(negedge clk); int_clr = 0;
    check("R10 pending re-sets while condition holds", 32'(int_pend[0]), 32'd1);
    int_en = 4'b0001; #0;
    check("R10 irq from tx need", 32'(irq), 32'd1);
    int_en = 4'b0000; @(negedge clk);

    // transmit flush
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); tx_push = 1; tx_wdata = $urandom;
      @(negedge clk); tx_push = 0;
    end
    repeat (60) @(negedge clk);
    tx_clr = 1; @(negedge clk); tx_clr = 0;
    check("R11 tx flush not immediate", 32'(tx_empty), 32'd0);
    repeat (80) @(negedge clk);
    check("R11 tx flushed", 32'(tx_empty), 32'd1);
    tx_round(3, 32'h0000_0000, 0, 2'd0);

    // receive flush
    @(negedge bclk);
    for (int i = 0; i < 7; i++) begin
      fe_rx_push = 1; fe_rx_data = $urandom; @(negedge bclk);
    end
    fe_rx_push = 0;
    repeat (20) @(negedge clk);
    rx_clr = 1; @(negedge clk); rx_clr = 0;
    check("R11 rx flush not immediate", 32'(rx_has_data), 32'd1);
    repeat (80) @(negedge clk);
    check("R11 rx flushed", 32'(rx_has_data), 32'd0);
    rx_round(2, 32'h0000_0000, 0, 2'd0);

    // sync echo
    sync_we = 1; sync_wdata = 1; @(negedge clk); sync_we = 0;
    check("R12 sync not yet echoed", 32'(sync_rd), 32'd0);
    repeat (60) @(negedge clk);
    check("R12 sync echoed 1", 32'(sync_rd), 32'd1);
    sync_we = 1; sync_wdata = 0; @(negedge clk); sync_we = 0;
    check("R12 sync holds old 1", 32'(sync_rd), 32'd1);
    repeat (60) @(negedge clk);
    check("R12 sync echoed 0", 32'(sync_rd), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule